// File: doc/BRIEF.md
# Round-Robin Multi-Channel Sigma-Delta DAC

This block produces many independent one-bit pulse-density outputs. Each output comes from a first-order sigma-delta modulator, and all channels share a single adder. The per-channel accumulator and level values live in two small synchronous RAMs rather than in flip-flops.

A sequencer visits the channels in a fixed cyclic order, one per clock. On each visit the block reads the channel's accumulator and level, adds them, writes the truncated sum back, and loads the carry into that channel's output flip-flop. With NCH channels, each output therefore advances once every NCH clocks. Its bit stream is the same as a dedicated modulator would produce, only stretched in time. Each output is meant to feed an external low-pass filter.

After reset the block sweeps both RAMs to zero over NCH cycles. During that sweep the outputs stay low and host writes are dropped. A host port writes a channel's level at any time once the sweep is done.

Top module: `sdm_rr_dac`

## Requirements
- R1: While `rst_i` is high, and for exactly NCH cycles after it is released, `ready_o` is 0 and every bit of `dac_o` is 0. `ready_o` reads 1 from the NCH-th clock edge after release onward.
- R2: Once ready, one channel is visited per clock in ascending order 0, 1, …, NCH-1. The first visit after the sweep is channel 0.
- R3: A visit computes s = acc + level, using DW-bit unsigned values. It stores s mod 2^DW back as the channel's accumulator. The bit s[DW] appears on `dac_o[ch]` two clock edges after the cycle in which the channel was read.
- R4: An output bit changes only as the result of a visit to its own channel. At most one bit of `dac_o` changes per clock.
- R5: A level write takes effect at the channel's next read. If the write lands in the same cycle that the channel is read, that visit still uses the old level.
- R6: Host writes made while `ready_o` is 0 are discarded. Each level starts at 0 after reset.
- R7: A level of 0 keeps the output at 0 permanently. A level of 2^DW-1 gives one 0 in every 2^DW visits.
- R8: After channel NCH-1 the visit order wraps to channel 0, including when NCH is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| host_wr_i | input | 1 | Level write strobe |
| host_ch_i | input | CW | Channel addressed by the write |
| host_level_i | input | DW | New level value |
| ready_o | output | 1 | High once the clearing sweep has finished |
| dac_o | output | NCH | One pulse-density bit per channel |

## Verification
The bench keeps its own accumulator for every channel and predicts each visit's carry two cycles ahead of the output. It therefore catches a pipeline that is off by a cycle, or that adds the wrong channel's level. It uses a channel count that is not a power of two, so a counter that wraps at the next power of two would desynchronise every later channel. A write lands exactly in the read cycle of its channel, which separates read-old from read-new RAM behaviour. A write issued during the sweep must leave its channel silent, which exposes a sweep that yields the RAM port to the host. On every cycle, any change to a channel other than the one due flags an output bank that loads the wrong bit.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  // Sequencer phase: clearing sweep after reset, then normal visits
  typedef enum logic {PH_SWEEP = 1'b0, PH_RUN = 1'b1} phase_t;
endpackage

// File: rtl/sdm_seq.sv
module sdm_seq #(
  parameter int NCH = 128,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  import sdm_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  phase_t ph;

  function automatic logic [CW-1:0] ch_next(input logic [CW-1:0] cur);
    return (cur == LAST) ? '0 : cur + 1'b1;
  endfunction

  // One counter serves both the sweep address and the visit channel
  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_SWEEP;
      cnt <= '0;
    end else begin
      cnt <= ch_next(cnt);
      if (ph == PH_SWEEP && cnt == LAST) ph <= PH_RUN;
    end
  end

  assign busy = (ph == PH_SWEEP);
endmodule

// File: rtl/sdm_ram.sv
module sdm_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  // Separate read and write ports; a same-address read returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/sdm_out_bank.sv
module sdm_out_bank #(
  parameter int NCH = 128,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic [CW-1:0]  ld_ch,
  input  logic           ld_bit,
  output logic [NCH-1:0] q
);
  for (genvar i = 0; i < NCH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                           q[i] <= 1'b0;
      else if (ld && ld_ch == CW'(i))    q[i] <= ld_bit;
    end
  end
endmodule

// File: rtl/sdm_rr_dac.sv
module sdm_rr_dac #(
  parameter int NCH = 128,
  parameter int DW  = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           host_wr_i,
  input  logic [CW-1:0]  host_ch_i,
  input  logic [DW-1:0]  host_level_i,
  output logic           ready_o,
  output logic [NCH-1:0] dac_o
);
  // Modulator step: {carry, new accumulator}
  function automatic logic [DW:0] sd_step(input logic [DW-1:0] acc,
                                          input logic [DW-1:0] lvl);
    return {1'b0, acc} + {1'b0, lvl};
  endfunction

  logic          busy;
  logic [CW-1:0] cnt;
  logic          rd_en;

  // Named internal events used by the checker
  logic          visit_fire;
  logic [CW-1:0] visit_ch;
  logic          visit_carry;
  logic          host_take;

  logic [DW-1:0] acc_q, lvl_q;
  logic [DW:0]   step;

  logic          acc_we, lvl_we;
  logic [CW-1:0] acc_wa, lvl_wa;
  logic [DW-1:0] acc_wd, lvl_wd;

  sdm_seq #(.NCH(NCH)) u_seq (
    .clk  (clk_i),
    .rst  (rst_i),
    .busy (busy),
    .cnt  (cnt)
  );

  assign rd_en = !busy;

  // Stage 1 marks the cycle where RAM read data is valid
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      visit_fire <= 1'b0;
      visit_ch   <= '0;
    end else begin
      visit_fire <= rd_en;
      visit_ch   <= cnt;
    end
  end

  assign step        = sd_step(acc_q, lvl_q);
  assign visit_carry = step[DW];

  // Accumulator RAM: the sweep clears it, then visits write back
  assign acc_we = busy | visit_fire;
  assign acc_wa = busy ? cnt : visit_ch;
  assign acc_wd = busy ? '0 : step[DW-1:0];

  sdm_ram #(.DEPTH(NCH), .W(DW)) u_acc_ram (
    .clk (clk_i),
    .we  (acc_we),
    .wa  (acc_wa),
    .wd  (acc_wd),
    .re  (rd_en),
    .ra  (cnt),
    .rd  (acc_q)
  );

  // Level RAM: the sweep owns the write port until it finishes
  assign host_take = host_wr_i & !busy;
  assign lvl_we    = busy | host_take;
  assign lvl_wa    = busy ? cnt : host_ch_i;
  assign lvl_wd    = busy ? '0 : host_level_i;

  sdm_ram #(.DEPTH(NCH), .W(DW)) u_lvl_ram (
    .clk (clk_i),
    .we  (lvl_we),
    .wa  (lvl_wa),
    .wd  (lvl_wd),
    .re  (rd_en),
    .ra  (cnt),
    .rd  (lvl_q)
  );

  sdm_out_bank #(.NCH(NCH)) u_out (
    .clk    (clk_i),
    .rst    (rst_i),
    .ld     (visit_fire),
    .ld_ch  (visit_ch),
    .ld_bit (visit_carry),
    .q      (dac_o)
  );

  assign ready_o = !busy;
endmodule

// File: rtl/sdm_chk.sv
module sdm_chk #(
  parameter int NCH = 128,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic [CW-1:0]  cnt,
  input logic           visit_fire,
  input logic [CW-1:0]  visit_ch,
  input logic           visit_carry,
  input logic           host_wr,
  input logic           host_take,
  input logic [NCH-1:0] dac
);
  localparam logic [CW-1:0] LAST = CW'(NCH - 1);

  // R1
  quiet_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> dac == '0);

  // R1
  sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt) == LAST);

  // R2
  rr_order_chk: assert property (@(posedge clk) disable iff (rst)
    (visit_fire && $past(visit_fire)) |->
      visit_ch == (($past(visit_ch) == LAST) ? '0 : $past(visit_ch) + 1'b1));

  // R3
  carry_out_chk: assert property (@(posedge clk) disable iff (rst)
    visit_fire |=> dac[$past(visit_ch)] == $past(visit_carry));

  // R4
  held_chk: assert property (@(posedge clk) disable iff (rst)
    !visit_fire |=> $stable(dac));

  // R4
  one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    visit_fire |=> $countones(dac ^ $past(dac)) <= 1);

  // R6
  sweep_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr) |-> !host_take);
endmodule

bind sdm_rr_dac sdm_chk #(.NCH(NCH)) u_chk (
  .clk         (clk_i),
  .rst         (rst_i),
  .busy        (busy),
  .cnt         (cnt),
  .visit_fire  (visit_fire),
  .visit_ch    (visit_ch),
  .visit_carry (visit_carry),
  .host_wr     (host_wr_i),
  .host_take   (host_take),
  .dac         (dac_o)
);

// File: tb/sdm_rr_dac_bench.sv
module sdm_rr_dac_bench;
  localparam int NCH = 6;
  localparam int DW  = 4;
  localparam int CW  = $clog2(NCH);
  localparam int NVISIT = 720;

  logic           clk = 1'b0;
  logic           rst;
  logic           host_wr;
  logic [CW-1:0]  host_ch;
  logic [DW-1:0]  host_level;
  logic           ready;
  logic [NCH-1:0] dac;

  always #10 clk = ~clk;

  sdm_rr_dac #(.NCH(NCH), .DW(DW)) u_sdm_rr_dac (
    .clk_i        (clk),
    .rst_i        (rst),
    .host_wr_i    (host_wr),
    .host_ch_i    (host_ch),
    .host_level_i (host_level),
    .ready_o      (ready),
    .dac_o        (dac)
  );

  typedef struct {
    int    due;
    int    ch;
    bit    val;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  int model_acc [NCH];
  int model_lvl [NCH];
  logic [NCH-1:0] prev_dac;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver side: model the visit read in cycle k and queue its result
  task automatic model_visit(input int k);
    int c;
    int s;
    exp_t e;
    c = k % NCH;
    s = model_acc[c] + model_lvl[c];
    model_acc[c] = s % (1 << DW);
    e.due = k + 2;
    e.ch  = c;
    e.val = (s >= (1 << DW));
    if (k == 303)                     e.req = "R5";
    else if (c == 0 && k >= NCH)      e.req = "R8";
    else if (c == 0 || c == 2)        e.req = "R7";
    else if (c == 1)                  e.req = "R6";
    else                              e.req = "R3";
    exp_q.push_back(e);
  endtask

  // Monitor side: compare every result due in cycle k and check holding
  task automatic monitor(input int k);
    logic [NCH-1:0] allowed;
    allowed = '0;
    while (exp_q.size() > 0 && exp_q[0].due == k) begin
      exp_t e;
      e = exp_q.pop_front();
      allowed[e.ch] = 1'b1;
      check(dac[e.ch] == e.val, e.req,
            $sformatf("R2 channel %0d bit at cycle %0d", e.ch, k),
            int'(dac[e.ch]), int'(e.val));
    end
    // R4: only the channel due this cycle may have moved
    check(((dac ^ prev_dac) & ~allowed) == '0, "R4", "undue output change",
          int'(dac), int'(prev_dac));
    check(ready == 1'b1, "R1", "ready after sweep", int'(ready), 1);
    prev_dac = dac;
  endtask

  task automatic drive(input int k);
    host_wr = 1'b0;
    case (k)
      1:   begin host_wr = 1; host_ch = 0; host_level = 4'd0;  end
      2:   begin host_wr = 1; host_ch = 2; host_level = 4'd15; end
      3:   begin host_wr = 1; host_ch = 3; host_level = 4'd8;  end
      4:   begin host_wr = 1; host_ch = 4; host_level = 4'd5;  end
      5:   begin host_wr = 1; host_ch = 5; host_level = 4'd1;  end
      303: begin host_wr = 1; host_ch = 3; host_level = 4'd3;  end // R5: same cycle as read of 3
      450: begin host_wr = 1; host_ch = 5; host_level = 4'd11; end
      default: ;
    endcase
    if (host_wr) model_lvl[host_ch] = int'(host_level);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      model_acc[i] = 0;
      model_lvl[i] = 0;
    end
    rst = 1; host_wr = 0; host_ch = '0; host_level = '0;
    repeat (3) @(negedge clk);
    check(ready == 1'b0 && dac == '0, "R1", "state in reset",
          int'({ready, dac}), 0);
    rst = 0;
    for (int i = 1; i <= NCH; i++) begin
      @(negedge clk);
      host_wr = 1'b0;
      if (i == 2) begin // R6: write during the sweep must be dropped
        host_wr = 1'b1; host_ch = 1; host_level = 4'd13;
      end
      check(ready == (i == NCH), "R1", $sformatf("ready after %0d edges", i),
            int'(ready), int'(i == NCH));
      check(dac == '0, "R1", "outputs during sweep", int'(dac), 0);
    end
    prev_dac = dac;
    for (int k = 0; k < NVISIT; k++) begin
      if (k > 0) @(negedge clk);
      monitor(k);
      model_visit(k);
      drive(k);
    end
    finish_run();
  end
endmodule